// File: doc/BRIEF.md
# SPI Sensor Register-Access Master

This block is the master end of a four-wire serial link to a sensor whose registers are reached through a split address header. One command moves one frame: a single-register write, or a read of one or more consecutive registers. The block lowers chip select and runs a mode-0 serial clock from a parameterised divider. It sends two header bytes and then either sends a data byte or collects data bytes from the sensor. After that it raises chip select and reports completion.

The header splits the 8-bit register address unevenly. The first byte starts with the direction flag and then carries the seven low address bits. The second byte carries only the top address bit, at its MSB. A burst read continues in blocks of eight clocks after the header, and the sensor steps its own address for each block. The master keeps no address counter. It only counts bytes. Each received byte appears on a read-data port with a one-cycle strobe.

Top module: `spi_regacc_master`

## Requirements
- R1: While reset is asserted, and after reset until a command is accepted, the outputs are `cs_n`=1, `sclk`=0, `mosi`=0, `busy`=0, `done`=0 and `rd_valid`=0.
- R2: `sclk` idles low and toggles only while `cs_n` is low. Its first rising edge comes CLK_DIV system cycles after `cs_n` falls, and each half period lasts CLK_DIV system cycles.
- R3: Header byte 0 goes out MSB first. Its bit 7 is 1 for a write and 0 for a read, and bits 6..0 are address bits 6..0. `mosi` is valid when `cs_n` falls and changes only when `sclk` falls.
- R4: Header byte 1 carries address bit 7 in its bit 7, and its remaining seven bits are driven as 0.
- R5: A write frame has exactly 24 `sclk` pulses, and its third byte is `cmd_wdata`, MSB first.
- R6: A read frame has 16 + 8*(`cmd_len`+1) `sclk` pulses, and `mosi` is 0 after the header. `miso` is sampled on the system clock edge where `sclk` rises, and the bits are assembled MSB first into `rd_data`.
- R7: `rd_valid` is a one-cycle pulse. It rises in the cycle after the rising edge that completes each data byte, so a read produces exactly `cmd_len`+1 pulses, in register order.
- R8: `cs_n` rises CLK_DIV cycles after the last falling edge of `sclk`. `done` is high for exactly the first cycle in which `cs_n` is high again.
- R9: A command is accepted only when `cmd_valid` is high, `busy` is low and `cmd_op` is 2'b01 (write) or 2'b10 (read). Opcodes 2'b00 and 2'b11, and any command presented while `busy` is high, have no effect.
- R10: `busy` is high from the cycle after acceptance until CLK_DIV cycles after `cs_n` has risen, and it covers the whole frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Opcode: 2'b01 write, 2'b10 read, others ignored |
| cmd_addr | input | 8 | Register address |
| cmd_wdata | input | 8 | Data byte for a write |
| cmd_len | input | LEN_W | Bytes to read minus one |
| busy | output | 1 | Frame in progress; commands refused |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| rd_data | output | 8 | Received register byte |
| done | output | 1 | One-cycle end-of-frame pulse |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to sensor |
| miso | input | 1 | Serial data from sensor |

## Verification
The assertions assume that `miso` is a synchronous signal that settles well before the next rising edge of `sclk`. They also assume that a command is offered with a legal opcode for at least one cycle and that reset is applied at time zero. The bench stimulus stays within these limits. A behavioural sensor in the bench changes `miso` only on a falling edge of `sclk`, which leaves CLK_DIV cycles of margin. The bench also presents some commands while `busy` is high and some with reserved opcodes, so that the refusal paths run without breaking the assumed input contract.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;

   typedef enum logic [1:0] {
      OPC_NOP = 2'b00,
      OPC_WR  = 2'b01,
      OPC_RD  = 2'b10,
      OPC_RSV = 2'b11
   } opc_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_LEAD,
      SQ_SHIFT,
      SQ_TAIL,
      SQ_GAP
   } sq_e;

   localparam int unsigned HDR_BITS  = 16;
   localparam int unsigned BYTE_BITS = 8;
   localparam int unsigned WR_BITS   = HDR_BITS + BYTE_BITS;

   // first header byte: direction flag over the seven low address bits
   function automatic logic [7:0] mk_hdr0(input logic wr, input logic [7:0] a);
      return {wr, a[6:0]};
   endfunction

   // second header byte: top address bit, filler driven low
   function automatic logic [7:0] mk_hdr1(input logic [7:0] a);
      return {a[7], 7'b000_0000};
   endfunction

endpackage

// File: rtl/spi_regacc_tick.sv
module spi_regacc_tick #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [CW-1:0] cnt;

   assign tick = run && (cnt == CW'(DIV - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + CW'(1);
      end
   end

endmodule

// File: rtl/spi_regacc_seq.sv
module spi_regacc_seq
   import spi_regacc_pkg::*;
#(
   parameter int unsigned LEN_W  = 4,
   parameter int unsigned BITS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic [LEN_W-1:0] cmd_len,
   input  logic             tick,
   output logic             busy,
   output logic             cs_n,
   output logic             sclk,
   output logic             done,
   output logic             load,
   output logic             rise,
   output logic             fall,
   output logic             is_read
);

   sq_e               state;
   logic [BITS_W-1:0] frame_bits;
   logic [BITS_W-1:0] falls;
   logic [BITS_W-1:0] rd_bits;
   logic              legal;

   assign legal   = (cmd_op == OPC_WR) || (cmd_op == OPC_RD);
   assign load    = (state == SQ_IDLE) && cmd_valid && legal;
   assign rise    = tick && ((state == SQ_LEAD) || ((state == SQ_SHIFT) && !sclk));
   assign fall    = tick && (state == SQ_SHIFT) && sclk;
   assign busy    = (state != SQ_IDLE);
   assign rd_bits = BITS_W'(HDR_BITS) + ((BITS_W'(cmd_len) + BITS_W'(1)) << 3);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= SQ_IDLE;
         cs_n       <= 1'b1;
         sclk       <= 1'b0;
         done       <= 1'b0;
         falls      <= '0;
         frame_bits <= '0;
         is_read    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            SQ_IDLE: begin
               if (load) begin
                  state      <= SQ_LEAD;
                  cs_n       <= 1'b0;
                  falls      <= '0;
                  is_read    <= (cmd_op == OPC_RD);
                  frame_bits <= (cmd_op == OPC_RD) ? rd_bits : BITS_W'(WR_BITS);
               end
            end
            SQ_LEAD: begin
               if (tick) begin
                  sclk  <= 1'b1;
                  state <= SQ_SHIFT;
               end
            end
            SQ_SHIFT: begin
               if (tick) begin
                  if (sclk) begin
                     sclk  <= 1'b0;
                     falls <= falls + BITS_W'(1);
                     if (falls + BITS_W'(1) == frame_bits) begin
                        state <= SQ_TAIL;
                     end
                  end else begin
                     sclk <= 1'b1;
                  end
               end
            end
            SQ_TAIL: begin
               if (tick) begin
                  cs_n  <= 1'b1;
                  done  <= 1'b1;
                  state <= SQ_GAP;
               end
            end
            SQ_GAP: begin
               if (tick) begin
                  state <= SQ_IDLE;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/spi_regacc_shift.sv
module spi_regacc_shift
   import spi_regacc_pkg::*;
#(
   parameter int unsigned BITS_W = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] hdr0,
   input  logic [7:0] hdr1,
   input  logic [7:0] wbyte,
   input  logic       is_read,
   input  logic       rise,
   input  logic       fall,
   input  logic       miso,
   output logic       mosi,
   output logic       rd_valid,
   output logic [7:0] rd_data
);

   logic [WR_BITS-1:0] tx_sr;
   logic [6:0]         rx_sr;
   logic [BITS_W-1:0]  nrx;
   logic               last_bit;

   assign mosi     = tx_sr[WR_BITS-1];
   assign last_bit = is_read && (nrx >= BITS_W'(HDR_BITS)) && (nrx[2:0] == 3'b111);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_sr    <= '0;
         rx_sr    <= '0;
         nrx      <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= 1'b0;
         if (load) begin
            tx_sr <= {hdr0, hdr1, wbyte};
            nrx   <= '0;
         end else begin
            if (fall) begin
               tx_sr <= {tx_sr[WR_BITS-2:0], 1'b0};
            end
            if (rise) begin
               rx_sr <= {rx_sr[5:0], miso};
               nrx   <= nrx + BITS_W'(1);
               if (last_bit) begin
                  rd_valid <= 1'b1;
                  rd_data  <= {rx_sr, miso};
               end
            end
         end
      end
   end

endmodule

// File: rtl/spi_regacc_master.sv
module spi_regacc_master
   import spi_regacc_pkg::*;
#(
   parameter int unsigned CLK_DIV = 4,
   parameter int unsigned LEN_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic [7:0]       cmd_addr,
   input  logic [7:0]       cmd_wdata,
   input  logic [LEN_W-1:0] cmd_len,
   output logic             busy,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic             done,
   output logic             cs_n,
   output logic             sclk,
   output logic             mosi,
   input  logic             miso
);

   localparam int unsigned MAX_BITS = HDR_BITS + BYTE_BITS * (2 ** LEN_W);
   localparam int unsigned BITS_W   = $clog2(MAX_BITS + 1);

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (LEN_W < 1 || LEN_W > 8) begin : g_bad_len
         $error("LEN_W must lie in 1..8");
      end
   endgenerate

   logic       tick;
   logic       load;
   logic       rise;
   logic       fall;
   logic       is_read;
   logic [7:0] hdr0;
   logic [7:0] hdr1;
   logic [7:0] wbyte;

   assign hdr0  = mk_hdr0(cmd_op == OPC_WR, cmd_addr);
   assign hdr1  = mk_hdr1(cmd_addr);
   assign wbyte = (cmd_op == OPC_WR) ? cmd_wdata : 8'h00;

   generate
      if (CLK_DIV == 1) begin : g_fast
         assign tick = busy;
      end else begin : g_div
         spi_regacc_tick #(.DIV(CLK_DIV)) u_tick (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (busy),
            .tick (tick)
         );
      end
   endgenerate

   spi_regacc_seq #(.LEN_W(LEN_W), .BITS_W(BITS_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_valid(cmd_valid),
      .cmd_op   (cmd_op),
      .cmd_len  (cmd_len),
      .tick     (tick),
      .busy     (busy),
      .cs_n     (cs_n),
      .sclk     (sclk),
      .done     (done),
      .load     (load),
      .rise     (rise),
      .fall     (fall),
      .is_read  (is_read)
   );

   spi_regacc_shift #(.BITS_W(BITS_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .hdr0    (hdr0),
      .hdr1    (hdr1),
      .wbyte   (wbyte),
      .is_read (is_read),
      .rise    (rise),
      .fall    (fall),
      .miso    (miso),
      .mosi    (mosi),
      .rd_valid(rd_valid),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/spi_regacc_master_chk.sv
module spi_regacc_master_chk (
   input logic clk,
   input logic rst_n,
   input logic cmd_valid,
   input logic busy,
   input logic rd_valid,
   input logic done,
   input logic cs_n,
   input logic sclk,
   input logic mosi
);

   a_r2_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> !cs_n);

   a_r3_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(mosi));

   a_r6_valid_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !cs_n);

   a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   a_r8_done_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $rose(cs_n));

   a_r8_cs_rise_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> done);

   a_r8_cs_rise_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (!sclk && !$past(sclk)));

   a_r9_start_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> $past(cmd_valid && !busy));

   a_r10_busy_cover_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);

endmodule

bind spi_regacc_master spi_regacc_master_chk u_chk (.*);

// File: tb/spi_regacc_master_test.sv
`timescale 1ns/1ps
module spi_regacc_master_test;

   localparam int N  = 3;
   localparam int LW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'b00;
   logic [7:0]    cmd_addr = 8'h00;
   logic [7:0]    cmd_wdata = 8'h00;
   logic [LW-1:0] cmd_len = '0;
   logic          busy, rd_valid, done, cs_n, sclk, mosi;
   logic [7:0]    rd_data;
   logic          miso = 1'b0;

   int nchecks = 0;
   int nerr = 0;
   bit over = 0;

   always #2 clk = ~clk;

   spi_regacc_master #(.CLK_DIV(N), .LEN_W(LW)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
      .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
      .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
   );

   // behavioural sensor: register file with auto-incrementing reads
   logic [7:0]  smem [256];
   int          s_rises, s_falls;
   logic [23:0] s_rx;
   logic        s_rw;
   logic [7:0]  s_addr;
   logic        ps_sclk = 1'b0;

   initial begin
      for (int i = 0; i < 256; i++) smem[i] = 8'((i * 29 + 7) ^ (i >> 3));
   end

   always @(negedge clk) begin
      if (cs_n !== 1'b0) begin
         s_rises = 0;
         s_falls = 0;
         miso = 1'b0;
      end else begin
         if (sclk && !ps_sclk) begin
            s_rx = {s_rx[22:0], mosi};
            s_rises++;
            if (s_rises == 16) begin
               s_rw   = s_rx[15];
               s_addr = {s_rx[7], s_rx[14:8]};
            end
            if (s_rises == 24 && s_rw) smem[s_addr] = s_rx[7:0];
         end
         if (!sclk && ps_sclk) begin
            s_falls++;
            if (!s_rw && s_falls >= 16) begin
               int k;
               k = s_falls - 16;
               miso = smem[8'(s_addr + 8'(k / 8))][7 - (k % 8)];
            end else begin
               miso = 1'b0;
            end
         end
      end
      ps_sclk = sclk;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchecks++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic idle_check(input int cycles, input string tag);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         chk({tag, " cs_n idle"}, 32'(cs_n), 32'd1);
         chk({tag, " busy idle"}, 32'(busy), 32'd0);
         chk({tag, " sclk idle"}, 32'(sclk), 32'd0);
         chk({tag, " mosi idle"}, 32'(mosi), 32'd0);
      end
   endtask

   // one frame, compared against the per-cycle reference on every clock
   task automatic run_frame(input logic [1:0] op, input logic [7:0] addr,
                            input logic [7:0] wdata, input int len, input bit poke);
      int B, T;
      bit wr;
      logic [23:0] f;
      wr = (op == 2'b01);
      B  = wr ? 24 : 16 + 8 * (len + 1);
      f  = {wr, addr[6:0], addr[7], 7'b0, wr ? wdata : 8'h00};
      T  = (2 * B + 2) * N;
      @(negedge clk);
      chk("R10 idle before command", 32'(busy), 32'd0);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_addr  = addr;
      cmd_wdata = wdata;
      cmd_len   = LW'(len);
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int t = 0; t <= T; t++) begin
         int  e, i, bi;
         bit  x_sclk, x_mosi, x_rv;
         string mtag;
         e = t / N;
         i = e / 2;
         x_sclk = (e % 2 == 1) && (e < 2 * B);
         x_mosi = (e < 2 * B && i < 24) ? f[23 - i] : 1'b0;
         bi = (e - 1) / 2;
         x_rv = !wr && (t % N == 0) && (e % 2 == 1) && (e < 2 * B) &&
                (bi >= 16) && ((bi - 16) % 8 == 7);
         if (i < 8) mtag = "R3 mosi byte0";
         else if (i < 16) mtag = "R4 mosi byte1";
         else if (wr) mtag = "R5 mosi wdata";
         else mtag = "R6 mosi low in data";
         chk("R2 sclk", 32'(sclk), 32'(x_sclk));
         chk(mtag, 32'(mosi), 32'(x_mosi));
         chk("R8 cs_n", 32'(cs_n), (t < (2 * B + 1) * N) ? 32'd0 : 32'd1);
         chk("R8 done", 32'(done), (t == (2 * B + 1) * N) ? 32'd1 : 32'd0);
         chk("R10 busy", 32'(busy), (t < (2 * B + 2) * N) ? 32'd1 : 32'd0);
         chk("R7 rd_valid", 32'(rd_valid), 32'(x_rv));
         if (x_rv)
            chk("R6 rd_data", 32'(rd_data), 32'(smem[8'(addr + 8'((bi - 16) / 8))]));
         if (poke) begin
            if (t == 5 * N) begin
               cmd_valid = 1'b1;
               cmd_op    = 2'b01;
               cmd_addr  = ~addr;
            end else if (t == 5 * N + 1) begin
               cmd_valid = 1'b0;
            end
         end
         if (t < T) @(negedge clk);
      end
      if (poke) idle_check(2 * N + 2, "R9 command while busy");
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R1 reset cs_n", 32'(cs_n), 32'd1);
      chk("R1 reset sclk", 32'(sclk), 32'd0);
      chk("R1 reset mosi", 32'(mosi), 32'd0);
      chk("R1 reset busy", 32'(busy), 32'd0);
      chk("R1 reset done", 32'(done), 32'd0);
      chk("R1 reset rd_valid", 32'(rd_valid), 32'd0);
      rst_n = 1'b1;
      idle_check(3, "R1 after reset");

      run_frame(2'b01, 8'h3A, 8'h3D, 0, 0);
      run_frame(2'b01, 8'hC5, 8'hA5, 3, 0);
      run_frame(2'b10, 8'hC5, 8'h00, 0, 0);
      run_frame(2'b10, 8'h3A, 8'h00, 0, 0);
      run_frame(2'b10, 8'h01, 8'h00, 5, 0);
      run_frame(2'b10, 8'h7E, 8'h00, 3, 1);

      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b00; cmd_addr = 8'h11;
      @(negedge clk);
      cmd_op = 2'b11;
      @(negedge clk);
      cmd_valid = 1'b0;
      idle_check(2 * N + 2, "R9 reserved opcode");

      run_frame(2'b10, 8'hF8, 8'h00, 15, 0);
      run_frame(2'b01, 8'h80, 8'h5A, 0, 0);
      run_frame(2'b10, 8'h80, 8'h00, 1, 0);

      if (!over) begin
         over = 1;
         $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!over) begin
         over = 1;
         nchecks++;
         nerr++;
         $display("FAIL watchdog R8 actual=hung expected=frame end");
         $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
         $finish;
      end
   end

endmodule